// File: doc/BRIEF.md
# Timer Compare Output Unit

This block watches one of two free-running 16-bit timer values and compares it against a programmed 16-bit compare value. The comparison runs on every clock cycle. When the two become equal, the unit carries out one programmed action on a single output pin: drive it high, drive it low, invert it, leave it alone and only raise an interrupt, or do nothing at all.

An action fires exactly once per match. It fires on the first cycle in which the selected timer equals the compare value. If the timer stalls on the matching value, nothing repeats until equality is lost and then found again. In every active mode a match also sets a sticky interrupt flag, provided interrupts are enabled. Software clears the flag with a one-cycle strobe. The timers themselves and the register write path sit outside this block; their values arrive as plain inputs.

Top module: `tcu_compare_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the pin output is 0 and the interrupt request is 0.
- R2: With the select input at 0, timer A is compared; with the select input at 1, timer B is compared. Equality on the unselected timer causes no action.
- R3: Mode code 4'b1000 drives the pin to 1 on a match.
- R4: Mode code 4'b1001 drives the pin to 0 on a match.
- R5: Mode code 4'b0010 inverts the pin level on each match.
- R6: Mode code 4'b1010 leaves the pin unchanged on a match and sets the interrupt flag.
- R7: Every mode code other than 4'b0010, 4'b1000, 4'b1001 and 4'b1010 leaves the pin at its last level and never sets the interrupt flag.
- R8: An action fires only on the first cycle of equality. While the selected timer stays equal to the compare value, the pin and the flag are not acted on again.
- R9: A match in any of the four active modes sets the interrupt flag only when the interrupt enable is 1.
- R10: The interrupt flag stays set until the clear strobe is applied. A strobe alone clears it at the next clock edge. A new match on the same cycle as the strobe wins, and the flag stays set.
- R11: The pin and the interrupt request change at the clock edge that samples the first cycle of equality, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_a_i | input | 16 | Timer A value |
| tmr_b_i | input | 16 | Timer B value |
| tmr_sel_i | input | 1 | Timer select: 0 chooses A, 1 chooses B |
| cmp_i | input | 16 | Compare value |
| mode_i | input | 4 | Action code applied on a match |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle strobe that clears the interrupt flag |
| pin_o | output | 1 | Output pin level |
| irq_o | output | 1 | Interrupt request (the sticky flag) |

## Verification
The bench holds the timer on the matching value for several cycles in toggle mode. A design that acts on the level of equality, rather than on its first cycle, would make the pin oscillate. It makes equality appear only on the unselected timer, which catches a swapped or ignored select. It applies a clear strobe on the same cycle as a new match, where the wrong priority would drop a fresh interrupt. It also samples the pin just before the matching edge, to catch an unregistered or early-firing path, and it exercises unused mode codes and a disabled interrupt, where a loose decode would drive the pin or raise the flag.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_TOGGLE   = 4'b0010;
    localparam logic [MODE_W-1:0] MODE_DRIVE_HI = 4'b1000;
    localparam logic [MODE_W-1:0] MODE_DRIVE_LO = 4'b1001;
    localparam logic [MODE_W-1:0] MODE_IRQ_ONLY = 4'b1010;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_HIGH   = 3'd1,
        ACT_LOW    = 3'd2,
        ACT_INVERT = 3'd3,
        ACT_IRQ    = 3'd4
    } act_e;

    typedef struct packed {
        logic eq_seen;
        logic pin;
        logic flag;
    } tcu_state_t;

endpackage

// File: rtl/tcu_timer_sel.sv
module tcu_timer_sel #(
    parameter int TMR_W = 16
) (
    input  logic [TMR_W-1:0] tmr_a_i,
    input  logic [TMR_W-1:0] tmr_b_i,
    input  logic             sel_i,
    output logic [TMR_W-1:0] tmr_o
);

    always_comb begin
        tmr_o = sel_i ? tmr_b_i : tmr_a_i;
    end

endmodule

// File: rtl/tcu_match_det.sv
module tcu_match_det #(
    parameter int TMR_W   = 16,
    parameter int SLICE_W = 8
) (
    input  logic [TMR_W-1:0] tmr_i,
    input  logic [TMR_W-1:0] cmp_i,
    output logic             eq_o
);

    localparam int NSLICE = (TMR_W + SLICE_W - 1) / SLICE_W;
    localparam int PAD_W  = NSLICE * SLICE_W;

    logic [PAD_W-1:0]  tmr_pad;
    logic [PAD_W-1:0]  cmp_pad;
    logic [NSLICE-1:0] slice_eq;

    always_comb begin
        tmr_pad = '0;
        cmp_pad = '0;
        tmr_pad[TMR_W-1:0] = tmr_i;
        cmp_pad[TMR_W-1:0] = cmp_i;
    end

    // Equality is built per slice and then reduced, to keep depth shallow.
    genvar gi;
    generate
        for (gi = 0; gi < NSLICE; gi++) begin : g_slice
            assign slice_eq[gi] =
                (tmr_pad[gi*SLICE_W +: SLICE_W] == cmp_pad[gi*SLICE_W +: SLICE_W]);
        end
    endgenerate

    assign eq_o = &slice_eq;

endmodule

// File: rtl/tcu_action_dec.sv
module tcu_action_dec
    import tcu_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output act_e              act_o,
    output logic              active_o
);

    always_comb begin
        unique case (mode_i)
            MODE_TOGGLE:   act_o = ACT_INVERT;
            MODE_DRIVE_HI: act_o = ACT_HIGH;
            MODE_DRIVE_LO: act_o = ACT_LOW;
            MODE_IRQ_ONLY: act_o = ACT_IRQ;
            default:       act_o = ACT_NONE;
        endcase
        active_o = (act_o != ACT_NONE);
    end

endmodule

// File: rtl/tcu_compare_unit.sv
module tcu_compare_unit
    import tcu_pkg::*;
#(
    parameter int TMR_W   = 16,
    parameter int SLICE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] tmr_a_i,
    input  logic [TMR_W-1:0] tmr_b_i,
    input  logic             tmr_sel_i,
    input  logic [TMR_W-1:0] cmp_i,
    input  logic [3:0]       mode_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    output logic             pin_o,
    output logic             irq_o
);

    logic [TMR_W-1:0] tmr_sel;
    logic             eq;
    logic             hit;
    act_e             act;
    logic             active;
    tcu_state_t       st_d;
    tcu_state_t       st_q;

    tcu_timer_sel #(.TMR_W(TMR_W)) u_sel (
        .tmr_a_i (tmr_a_i),
        .tmr_b_i (tmr_b_i),
        .sel_i   (tmr_sel_i),
        .tmr_o   (tmr_sel)
    );

    tcu_match_det #(.TMR_W(TMR_W), .SLICE_W(SLICE_W)) u_match (
        .tmr_i (tmr_sel),
        .cmp_i (cmp_i),
        .eq_o  (eq)
    );

    tcu_action_dec u_dec (
        .mode_i   (mode_i),
        .act_o    (act),
        .active_o (active)
    );

    // First cycle of equality only.
    assign hit = eq && !st_q.eq_seen;

    always_comb begin
        st_d         = st_q;
        st_d.eq_seen = eq;
        if (hit) begin
            unique case (act)
                ACT_HIGH:   st_d.pin = 1'b1;
                ACT_LOW:    st_d.pin = 1'b0;
                ACT_INVERT: st_d.pin = ~st_q.pin;
                default:    st_d.pin = st_q.pin;
            endcase
        end
        // A new match outranks the clear strobe.
        if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
        if (hit && active && irq_en_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.pin;
    assign irq_o = st_q.flag;

endmodule

// File: rtl/tcu_compare_unit_chk.sv
module tcu_compare_unit_chk #(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TMR_W-1:0] tmr_a_i,
    input logic [TMR_W-1:0] tmr_b_i,
    input logic             tmr_sel_i,
    input logic [TMR_W-1:0] cmp_i,
    input logic [3:0]       mode_i,
    input logic             irq_en_i,
    input logic             flag_clr_i,
    input logic             pin_o,
    input logic             irq_o
);

    logic seen_q;
    logic seen_valid_q;
    logic m_now;
    logic first;
    logic act_mode;

    assign m_now    = tmr_sel_i ? (tmr_b_i == cmp_i) : (tmr_a_i == cmp_i);
    assign first    = m_now && !seen_q;
    assign act_mode = (mode_i == 4'b0010) || (mode_i == 4'b1000) ||
                      (mode_i == 4'b1001) || (mode_i == 4'b1010);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q       <= 1'b0;
            seen_valid_q <= 1'b0;
        end else begin
            seen_q       <= m_now;
            seen_valid_q <= 1'b1;
        end
    end

    a_r3_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
        (first && mode_i == 4'b1000) |=> pin_o);

    a_r4_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
        (first && mode_i == 4'b1001) |=> !pin_o);

    a_r5_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (first && mode_i == 4'b0010) |=> (pin_o != $past(pin_o)));

    a_r6_irq_only_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (first && mode_i == 4'b1010) |=> $stable(pin_o));

    a_r7_idle_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (first && !act_mode) |=> $stable(pin_o));

    a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_valid_q && m_now && seen_q) |=> $stable(pin_o));

    a_r9_gated_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !irq_en_i) |=> !irq_o);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !(first && act_mode && irq_en_i)) |=> !irq_o);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (first && act_mode && irq_en_i) |=> irq_o);

endmodule

bind tcu_compare_unit tcu_compare_unit_chk #(.TMR_W(TMR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_a_i    (tmr_a_i),
    .tmr_b_i    (tmr_b_i),
    .tmr_sel_i  (tmr_sel_i),
    .cmp_i      (cmp_i),
    .mode_i     (mode_i),
    .irq_en_i   (irq_en_i),
    .flag_clr_i (flag_clr_i),
    .pin_o      (pin_o),
    .irq_o      (irq_o)
);

// File: tb/tcu_compare_unit_tb.sv
module tcu_compare_unit_tb_top;

    localparam logic [15:0] CMP  = 16'h1234;
    localparam logic [15:0] MISS = 16'h0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_a = MISS;
    logic [15:0] tmr_b = MISS;
    logic        tmr_sel = 1'b0;
    logic [15:0] cmp_v = CMP;
    logic [3:0]  mode = 4'b0000;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        pin;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tcu_compare_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_a_i    (tmr_a),
        .tmr_b_i    (tmr_b),
        .tmr_sel_i  (tmr_sel),
        .cmp_i      (cmp_v),
        .mode_i     (mode),
        .irq_en_i   (irq_en),
        .flag_clr_i (flag_clr),
        .pin_o      (pin),
        .irq_o      (irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Drop equality for one cycle so the next match counts as a first one.
    task automatic disarm();
        tmr_a = MISS;
        tmr_b = MISS;
        step();
    endtask

    task automatic match_a();
        tmr_a = CMP;
        step();
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pin in reset", pin, 1'b0);
        check("R1 irq in reset", irq, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 pin after reset", pin, 1'b0);
        check("R1 irq after reset", irq, 1'b0);
    endtask

    task automatic t_drive_high();
        tmr_sel = 1'b0; irq_en = 1'b1; mode = 4'b1000;
        disarm();
        match_a();
        check("R3 pin high", pin, 1'b1);
        check("R9 flag set", irq, 1'b1);
        clear_flag();
        check("R10 flag cleared", irq, 1'b0);
    endtask

    task automatic t_drive_low();
        mode = 4'b1001;
        disarm();
        match_a();
        check("R4 pin low", pin, 1'b0);
        clear_flag();
    endtask

    task automatic t_toggle_hold();
        mode = 4'b0010;
        disarm();
        match_a();
        check("R5 first invert", pin, 1'b1);
        clear_flag();
        for (int i = 0; i < 4; i++) begin
            step();
            check("R8 held match no repeat", pin, 1'b1);
        end
        check("R8 no flag on held match", irq, 1'b0);
        disarm();
        match_a();
        check("R5 second invert", pin, 1'b0);
        clear_flag();
    endtask

    task automatic t_irq_only();
        mode = 4'b0010;
        disarm();
        match_a();
        clear_flag();
        mode = 4'b1010;
        disarm();
        match_a();
        check("R6 pin kept", pin, 1'b1);
        check("R6 flag set", irq, 1'b1);
        clear_flag();
    endtask

    task automatic t_idle_modes();
        mode = 4'b0000;
        disarm();
        match_a();
        check("R7 code 0000 pin", pin, 1'b1);
        check("R7 code 0000 irq", irq, 1'b0);
        mode = 4'b1111;
        disarm();
        match_a();
        check("R7 code 1111 pin", pin, 1'b1);
        check("R7 code 1111 irq", irq, 1'b0);
    endtask

    task automatic t_irq_disabled();
        irq_en = 1'b0; mode = 4'b0010;
        disarm();
        match_a();
        check("R9 toggle still acts", pin, 1'b0);
        check("R9 no flag when disabled", irq, 1'b0);
        irq_en = 1'b1;
    endtask

    task automatic t_select();
        mode = 4'b1000; tmr_sel = 1'b1;
        disarm();
        tmr_a = CMP; tmr_b = MISS;
        step();
        check("R2 unselected A ignored", pin, 1'b0);
        check("R2 unselected A no irq", irq, 1'b0);
        tmr_b = CMP;
        step();
        check("R2 timer B acts", pin, 1'b1);
        clear_flag();
        tmr_sel = 1'b0;
    endtask

    task automatic t_clear_vs_set();
        mode = 4'b1010;
        disarm();
        match_a();
        disarm();
        tmr_a = CMP; flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        check("R10 set beats clear", irq, 1'b1);
        step();
        check("R10 flag sticky", irq, 1'b1);
        clear_flag();
        check("R10 later clear", irq, 1'b0);
    endtask

    task automatic t_timing();
        mode = 4'b1001;
        disarm();
        @(negedge clk);
        tmr_a = CMP;
        #1;
        check("R11 pin before edge", pin, 1'b1);
        check("R11 irq before edge", irq, 1'b0);
        @(posedge clk);
        #1;
        check("R11 pin after edge", pin, 1'b0);
        check("R11 irq after edge", irq, 1'b1);
        clear_flag();
    endtask

    initial begin
        #23;
        t_reset();
        t_drive_high();
        t_drive_low();
        t_toggle_hold();
        t_irq_only();
        t_idle_modes();
        t_irq_disabled();
        t_select();
        t_clear_vs_set();
        t_timing();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule